// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is a serial test access port for a chip's I/O ring. An external tester drives the test clock, the mode-select line and serial data in. It walks a 16-state controller, loads a 4-bit instruction, and shifts one of four data registers between serial input and serial output. The four registers are a one-bit pass-through, a 32-bit identification word, a boundary chain with two cells per I/O pin, and a debug transfer register. The debug register gives on-chip programming and debug logic a parallel word in each direction.

Pin-control outputs sit between the core's functional pin signals and the pads. For each pin they pass the core value, drive from the boundary update latches, or release the pin to high impedance, as the active instruction selects. The whole port runs on the test clock alone. It is held inert unless the enable fuse input is programmed and the disable bit is clear.

Top module: `jtag_tap`

## Requirements
- R1: The controller follows the 16-state test-access state graph on rising TCK edges under TMS. This includes the pause loop: Shift-DR → Exit1 → Pause → Exit2 → Shift-DR resumes shifting with no lost or repeated bit.
- R2: Five consecutive TCK rising edges with TMS high reach Test-Logic-Reset from any state. Asserting `trst` forces that state at once. Either way the instruction becomes IDCODE and every pin returns to its functional values.
- R3: The instruction register is 4 bits, shifted LSB first. It captures 4'b0001 in Capture-IR and takes its new value on the falling TCK edge in Update-IR. The opcodes are EXTEST 0x0, PRELOAD 0x1, SAMPLE 0x2, IDCODE 0x3, CLAMP 0x4, HIGHZ 0x5, DEBUG 0x7 and BYPASS 0xF.
- R4: IDCODE selects a 32-bit register whose LSB is 1. It loads `IDCODE_VAL` in Capture-DR and shifts out LSB first.
- R5: BYPASS and every undefined opcode select a one-bit register that captures 0, so shifted data reappears delayed by one bit.
- R6: SAMPLE and PRELOAD select the boundary chain of 2×N_PINS cells. Bit 2i captures `pin_in[i]` and bit 2i+1 captures `pin_func_oe[i]`, and the chain shifts out from bit 0. Update-DR copies the chain into the update latches. Pins keep their functional values throughout.
- R7: EXTEST selects the boundary chain and drives pin i with value = latch bit 2i and enable = latch bit 2i+1.
- R8: CLAMP drives the pins from the update latches exactly as EXTEST does, but selects the one-bit bypass register.
- R9: HIGHZ clears every pin output enable and selects the one-bit bypass register.
- R10: DEBUG (0x7) selects a DBG_W-bit register that captures `dbg_tx_data` in Capture-DR. On the falling edge in Update-DR it presents the shifted word on `dbg_rx_data` and raises `dbg_rx_valid` for exactly one TCK cycle.
- R11: TDO changes only on falling TCK edges, and `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR.
- R12: The port works only when `fuse_prog` is 1 and `tap_disable` is 0. Otherwise it is held in Test-Logic-Reset, `tdo_oe` stays 0 and the pins carry their functional values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| trst | input | 1 | Asynchronous active-high port reset |
| fuse_prog | input | 1 | Enable fuse, 1 = programmed |
| tap_disable | input | 1 | Disable bit, 1 = port off |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| tdo_oe | output | 1 | Output enable for TDO |
| pin_in | input | N_PINS | Levels observed at the pads |
| pin_func_out | input | N_PINS | Core output values |
| pin_func_oe | input | N_PINS | Core output enables |
| pin_out | output | N_PINS | Value to the pads |
| pin_oe | output | N_PINS | Output enable to the pads |
| dbg_tx_data | input | DBG_W | Word from the debug logic, captured for shifting out |
| dbg_rx_data | output | DBG_W | Word delivered to the debug logic |
| dbg_rx_valid | output | 1 | One-cycle strobe marking a new `dbg_rx_data` |

## Verification
The bench reads the identification word with a Pause-DR detour in the middle of the shift. A controller that shifted in Exit or Pause states would return a corrupted word. Undefined opcodes are driven to prove they fall back to the one-bit path; a decoder without a default would leave a stale chain selected. The bench checks that CLAMP keeps the preloaded pin values while the path shrinks to one bit, and that HIGHZ drops every enable. A pin mux keyed to the wrong instruction would show the latches or the core values at the wrong time. Reset is hit three ways: five TMS-high edges, the asynchronous `trst`, and each enable gate. Each way must hand the pins back to the core and mute TDO. A gate that only blocked TDO would leave EXTEST values on the pads.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int IR_W     = 4;
  localparam int TLR_ONES = 5;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {DR_BYP, DR_IDC, DR_BSR, DR_DBG} dr_sel_t;
  typedef enum logic [1:0] {PM_FUNC, PM_LATCH, PM_HIZ} pin_mode_t;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'h0;
  localparam logic [IR_W-1:0] OP_PRELOAD = 4'h1;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'h2;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'h3;
  localparam logic [IR_W-1:0] OP_CLAMP   = 4'h4;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 4'h5;
  localparam logic [IR_W-1:0] OP_DEBUG   = 4'h7;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_t state
);

  localparam int CNT_W = $clog2(TLR_ONES + 1);

  tap_state_t       nxt;
  logic [CNT_W-1:0] ones_cnt;

  always_comb begin
    case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or posedge rst) begin
    if (rst) begin
      state    <= ST_TLR;
      ones_cnt <= '0;
    end else begin
      state <= nxt;
      if (!tms)                                 ones_cnt <= '0;
      else if (ones_cnt != CNT_W'(TLR_ONES))    ones_cnt <= ones_cnt + 1'b1;
    end
  end

  assert_tlr_exit_R1: assert property (@(posedge tck) disable iff (rst)
    (state == ST_TLR && !tms) |=> state == ST_RTI);

  assert_five_ones_R2: assert property (@(posedge tck) disable iff (rst)
    (ones_cnt == CNT_W'(TLR_ONES)) |-> state == ST_TLR);

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
  import jtag_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst,
  input  tap_state_t      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir,
  output logic            ir_tdo_bit,
  output dr_sel_t         dr_sel,
  output pin_mode_t       pin_mode,
  output logic            bsr_upd_en
);

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or posedge rst) begin
    if (rst)                    ir_sr <= '0;
    else if (state == ST_CAP_IR) ir_sr <= IR_CAPTURE;
    else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  always_ff @(negedge tck or posedge rst) begin
    if (rst)                     ir <= OP_IDCODE;
    else if (state == ST_TLR)    ir <= OP_IDCODE;
    else if (state == ST_UPD_IR) ir <= ir_sr;
  end

  assign ir_tdo_bit = ir_sr[0];

  always_comb begin
    dr_sel     = DR_BYP;
    pin_mode   = PM_FUNC;
    bsr_upd_en = 1'b0;
    case (ir)
      OP_EXTEST:  begin dr_sel = DR_BSR; pin_mode = PM_LATCH; bsr_upd_en = 1'b1; end
      OP_PRELOAD,
      OP_SAMPLE:  begin dr_sel = DR_BSR; bsr_upd_en = 1'b1; end
      OP_IDCODE:  dr_sel = DR_IDC;
      OP_CLAMP:   pin_mode = PM_LATCH;
      OP_HIGHZ:   pin_mode = PM_HIZ;
      OP_DEBUG:   dr_sel = DR_DBG;
      default:    ;
    endcase
  end

  assert_ir_capture_R3: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_IR) |=> ir_sr == IR_CAPTURE);

endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int          N_PINS     = 8,
  parameter int          DBG_W      = 8,
  parameter logic [31:0] IDCODE_VAL = 32'h1A5C_903F,
  localparam int         BSR_W      = 2 * N_PINS
) (
  input  logic             tck,
  input  logic             rst,
  input  tap_state_t       state,
  input  logic             tdi,
  input  dr_sel_t          dr_sel,
  input  logic             bsr_upd_en,
  input  logic [N_PINS-1:0] pin_in,
  input  logic [N_PINS-1:0] pin_func_oe,
  input  logic [DBG_W-1:0] dbg_tx_data,
  output logic             dr_tdo_bit,
  output logic [BSR_W-1:0] bsr_upd,
  output logic [DBG_W-1:0] dbg_rx_data,
  output logic             dbg_rx_valid
);

  logic             byp_q;
  logic [31:0]      idc_sr;
  logic [BSR_W-1:0] bsr_sr;
  logic [BSR_W-1:0] bsr_cap;
  logic [DBG_W-1:0] dbg_sr;

  for (genvar i = 0; i < N_PINS; i++) begin : g_cap
    assign bsr_cap[2*i]   = pin_in[i];
    assign bsr_cap[2*i+1] = pin_func_oe[i];
  end

  always_ff @(posedge tck or posedge rst) begin
    if (rst) begin
      byp_q  <= 1'b0;
      idc_sr <= '0;
      bsr_sr <= '0;
      dbg_sr <= '0;
    end else if (state == ST_CAP_DR) begin
      case (dr_sel)
        DR_IDC:  idc_sr <= IDCODE_VAL;
        DR_BSR:  bsr_sr <= bsr_cap;
        DR_DBG:  dbg_sr <= dbg_tx_data;
        default: byp_q  <= 1'b0;
      endcase
    end else if (state == ST_SH_DR) begin
      case (dr_sel)
        DR_IDC:  idc_sr <= {tdi, idc_sr[31:1]};
        DR_BSR:  bsr_sr <= {tdi, bsr_sr[BSR_W-1:1]};
        DR_DBG:  dbg_sr <= {tdi, dbg_sr[DBG_W-1:1]};
        default: byp_q  <= tdi;
      endcase
    end
  end

  always_comb begin
    case (dr_sel)
      DR_IDC:  dr_tdo_bit = idc_sr[0];
      DR_BSR:  dr_tdo_bit = bsr_sr[0];
      DR_DBG:  dr_tdo_bit = dbg_sr[0];
      default: dr_tdo_bit = byp_q;
    endcase
  end

  always_ff @(negedge tck or posedge rst) begin
    if (rst) begin
      bsr_upd      <= '0;
      dbg_rx_data  <= '0;
      dbg_rx_valid <= 1'b0;
    end else begin
      dbg_rx_valid <= 1'b0;
      if (state == ST_UPD_DR) begin
        if (bsr_upd_en) bsr_upd <= bsr_sr;
        if (dr_sel == DR_DBG) begin
          dbg_rx_data  <= dbg_sr;
          dbg_rx_valid <= 1'b1;
        end
      end
    end
  end

  assert_idcode_lsb_R4: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_DR && dr_sel == DR_IDC) |=> idc_sr[0] && idc_sr == IDCODE_VAL);

  assert_bypass_zero_R5: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_DR && dr_sel == DR_BYP) |=> !byp_q);

  assert_dbg_strobe_R10: assert property (@(posedge tck) disable iff (rst)
    dbg_rx_valid |-> state == ST_UPD_DR);

endmodule

// File: rtl/jtag_tap.sv
module jtag_tap
  import jtag_tap_pkg::*;
#(
  parameter int          N_PINS     = 8,
  parameter int          DBG_W      = 8,
  parameter logic [31:0] IDCODE_VAL = 32'h1A5C_903F
) (
  input  logic              tck,
  input  logic              tms,
  input  logic              tdi,
  input  logic              trst,
  input  logic              fuse_prog,
  input  logic              tap_disable,
  output logic              tdo,
  output logic              tdo_oe,
  input  logic [N_PINS-1:0] pin_in,
  input  logic [N_PINS-1:0] pin_func_out,
  input  logic [N_PINS-1:0] pin_func_oe,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  input  logic [DBG_W-1:0]  dbg_tx_data,
  output logic [DBG_W-1:0]  dbg_rx_data,
  output logic              dbg_rx_valid
);

  localparam int BSR_W = 2 * N_PINS;

  logic             rst_any;
  tap_state_t       state;
  logic [IR_W-1:0]  ir;
  logic             ir_tdo_bit;
  logic             dr_tdo_bit;
  dr_sel_t          dr_sel;
  pin_mode_t        pin_mode;
  logic             bsr_upd_en;
  logic [BSR_W-1:0] bsr_upd;

  assign rst_any = trst | ~fuse_prog | tap_disable;

  jtag_tap_fsm u_fsm (
    .tck   (tck),
    .rst   (rst_any),
    .tms   (tms),
    .state (state)
  );

  jtag_tap_ir u_ir (
    .tck        (tck),
    .rst        (rst_any),
    .state      (state),
    .tdi        (tdi),
    .ir         (ir),
    .ir_tdo_bit (ir_tdo_bit),
    .dr_sel     (dr_sel),
    .pin_mode   (pin_mode),
    .bsr_upd_en (bsr_upd_en)
  );

  jtag_tap_dr #(
    .N_PINS     (N_PINS),
    .DBG_W      (DBG_W),
    .IDCODE_VAL (IDCODE_VAL)
  ) u_dr (
    .tck          (tck),
    .rst          (rst_any),
    .state        (state),
    .tdi          (tdi),
    .dr_sel       (dr_sel),
    .bsr_upd_en   (bsr_upd_en),
    .pin_in       (pin_in),
    .pin_func_oe  (pin_func_oe),
    .dbg_tx_data  (dbg_tx_data),
    .dr_tdo_bit   (dr_tdo_bit),
    .bsr_upd      (bsr_upd),
    .dbg_rx_data  (dbg_rx_data),
    .dbg_rx_valid (dbg_rx_valid)
  );

  always_ff @(negedge tck or posedge rst_any) begin
    if (rst_any) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
      if (state == ST_SH_IR)      tdo <= ir_tdo_bit;
      else if (state == ST_SH_DR) tdo <= dr_tdo_bit;
    end
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    always_comb begin
      case (pin_mode)
        PM_LATCH: begin pin_out[i] = bsr_upd[2*i]; pin_oe[i] = bsr_upd[2*i+1]; end
        PM_HIZ:   begin pin_out[i] = 1'b0;         pin_oe[i] = 1'b0;           end
        default:  begin pin_out[i] = pin_func_out[i]; pin_oe[i] = pin_func_oe[i]; end
      endcase
    end
  end

  assert_tdo_in_shift_R11: assert property (@(posedge tck) disable iff (rst_any)
    tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

  assert_highz_release_R9: assert property (@(posedge tck) disable iff (rst_any)
    (ir == OP_HIGHZ) |-> pin_oe == '0);

  assert_gated_functional_R12: assert property (@(posedge tck) disable iff (trst)
    (!fuse_prog || tap_disable) |-> (!tdo_oe && pin_out == pin_func_out && pin_oe == pin_func_oe));

endmodule

// File: tb/jtag_tap_bench.sv
`timescale 1ns/1ps
module jtag_tap_bench;

  localparam int          N_PINS = 8;
  localparam int          DBG_W  = 8;
  localparam int          BSR_W  = 2 * N_PINS;
  localparam logic [31:0] IDC    = 32'h1A5C_903F;

  logic tck = 1'b0;
  logic tms = 1'b1, tdi = 1'b0, trst = 1'b1, fuse_prog = 1'b1, tap_disable = 1'b0;
  logic tdo, tdo_oe, dbg_rx_valid;
  logic [N_PINS-1:0] pin_in = '0, pin_func_out = '0, pin_func_oe = '0, pin_out, pin_oe;
  logic [DBG_W-1:0]  dbg_tx_data = '0, dbg_rx_data;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0, saw_oe = 1'b0, last_valid = 1'b0;

  always #5 tck = ~tck;

  jtag_tap #(.N_PINS(N_PINS), .DBG_W(DBG_W), .IDCODE_VAL(IDC)) u_jtag_tap (
    .tck(tck), .tms(tms), .tdi(tdi), .trst(trst), .fuse_prog(fuse_prog),
    .tap_disable(tap_disable), .tdo(tdo), .tdo_oe(tdo_oe), .pin_in(pin_in),
    .pin_func_out(pin_func_out), .pin_func_oe(pin_func_oe), .pin_out(pin_out),
    .pin_oe(pin_oe), .dbg_tx_data(dbg_tx_data), .dbg_rx_data(dbg_rx_data),
    .dbg_rx_valid(dbg_rx_valid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [BSR_W-1:0] cap_vec(input logic [N_PINS-1:0] pi, input logic [N_PINS-1:0] oe);
    logic [BSR_W-1:0] v;
    for (int i = 0; i < N_PINS; i++) begin
      v[2*i]   = pi[i];
      v[2*i+1] = oe[i];
    end
    return v;
  endfunction

  function automatic logic [N_PINS-1:0] even_bits(input logic [BSR_W-1:0] v);
    logic [N_PINS-1:0] r;
    for (int i = 0; i < N_PINS; i++) r[i] = v[2*i];
    return r;
  endfunction

  function automatic logic [N_PINS-1:0] odd_bits(input logic [BSR_W-1:0] v);
    logic [N_PINS-1:0] r;
    for (int i = 0; i < N_PINS; i++) r[i] = v[2*i+1];
    return r;
  endfunction

  task automatic step(input logic m, input logic d, output logic o);
    tms = m; tdi = d; o = tdo;
    if (tdo_oe) saw_oe = 1'b1;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic shift_dr(input logic [63:0] din, input int n, input int pause_at,
                          output logic [63:0] dout);
    logic b;
    dout = '0;
    step(1'b1, 1'b0, b); step(1'b0, 1'b0, b); step(1'b0, 1'b0, b);
    for (int i = 0; i < n; i++) begin
      step((i == n - 1) || (i == pause_at), din[i], b);
      dout[i] = b;
      if (i == pause_at && i != n - 1) begin
        step(1'b0, 1'b0, b); step(1'b0, 1'b0, b); step(1'b1, 1'b0, b); step(1'b0, 1'b0, b);
      end
    end
    step(1'b1, 1'b0, b);
    last_valid = dbg_rx_valid;
    step(1'b0, 1'b0, b);
  endtask

  task automatic shift_ir(input logic [3:0] op, output logic [3:0] cap);
    logic b;
    step(1'b1, 1'b0, b); step(1'b1, 1'b0, b); step(1'b0, 1'b0, b); step(1'b0, 1'b0, b);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i], b);
      cap[i] = b;
    end
    step(1'b1, 1'b0, b); step(1'b0, 1'b0, b);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] d, r;
    logic [3:0]  c;
    logic [BSR_W-1:0] p;
    logic b;
    void'($urandom(32'd4871));
    @(negedge tck); #1;
    repeat (3) begin @(negedge tck); #1; end
    pin_func_out = 8'hA5; pin_func_oe = 8'h3C;
    #1;
    // R2 / R12: reset state
    check("R2 pins functional in reset", {pin_oe, pin_out}, {8'h3C, 8'hA5});
    check("R11 tdo_oe idle", tdo_oe, 0);
    trst = 1'b0;
    step(1'b0, 1'b0, b);

    // R4 IDCODE with pause detour (R1)
    saw_oe = 1'b0;
    shift_dr(64'h0, 32, 11, r);
    check("R1 R4 idcode through pause", r[31:0], IDC);
    check("R4 idcode lsb", r[0], 1);
    check("R11 tdo_oe seen in shift", saw_oe, 1);
    check("R11 tdo_oe off in idle", tdo_oe, 0);

    // R3 IR capture
    shift_ir(4'hF, c);
    check("R3 ir capture", c, 4'b0001);

    // R5 bypass, directed + random
    for (int k = 0; k < 3; k++) begin
      d = 64'($urandom & 32'hFF);
      shift_dr(d, 8, -1, r);
      check("R5 bypass delay", r[7:0], {d[6:0], 1'b0});
    end
    shift_ir(4'hA, c);
    d = 64'h96;
    shift_dr(d, 8, -1, r);
    check("R5 undefined opcode bypass", r[7:0], {d[6:0], 1'b0});

    // R6 SAMPLE
    for (int k = 0; k < 3; k++) begin
      pin_in = N_PINS'($urandom); pin_func_out = N_PINS'($urandom); pin_func_oe = N_PINS'($urandom);
      shift_ir(4'h2, c);
      shift_dr(64'h0, BSR_W, -1, r);
      check("R6 sample capture", r[BSR_W-1:0], cap_vec(pin_in, pin_func_oe));
      check("R6 sample pins functional", {pin_oe, pin_out}, {pin_func_oe, pin_func_out});
    end

    // R6 PRELOAD then R7 EXTEST
    p = BSR_W'($urandom);
    shift_ir(4'h1, c);
    shift_dr(64'(p), BSR_W, -1, r);
    check("R6 preload pins functional", {pin_oe, pin_out}, {pin_func_oe, pin_func_out});
    shift_ir(4'h0, c);
    check("R7 extest drives latches", {pin_oe, pin_out}, {odd_bits(p), even_bits(p)});
    pin_in = N_PINS'($urandom);
    shift_dr(64'(p), BSR_W, -1, r);
    check("R7 extest chain selected", r[BSR_W-1:0], cap_vec(pin_in, pin_func_oe));
    check("R7 extest latches kept", {pin_oe, pin_out}, {odd_bits(p), even_bits(p)});

    // R8 CLAMP
    shift_ir(4'h4, c);
    check("R8 clamp drives latches", {pin_oe, pin_out}, {odd_bits(p), even_bits(p)});
    d = 64'h5B;
    shift_dr(d, 8, -1, r);
    check("R8 clamp bypass path", r[7:0], {d[6:0], 1'b0});

    // R9 HIGHZ
    shift_ir(4'h5, c);
    check("R9 highz enables off", pin_oe, 0);
    d = 64'hC3;
    shift_dr(d, 8, -1, r);
    check("R9 highz bypass path", r[7:0], {d[6:0], 1'b0});

    // R10 DEBUG
    shift_ir(4'h7, c);
    for (int k = 0; k < 2; k++) begin
      dbg_tx_data = DBG_W'($urandom);
      d = 64'($urandom & 32'hFF);
      shift_dr(d, DBG_W, -1, r);
      check("R10 debug capture", r[DBG_W-1:0], dbg_tx_data);
      check("R10 debug rx data", dbg_rx_data, d[DBG_W-1:0]);
      check("R10 debug strobe high", last_valid, 1);
      check("R10 debug strobe cleared", dbg_rx_valid, 0);
    end

    // R2 five TMS ones
    shift_ir(4'h0, c);
    shift_dr(64'(p), BSR_W, -1, r);
    step(1'b1, 1'b0, b); step(1'b0, 1'b0, b); step(1'b0, 1'b0, b);
    repeat (5) step(1'b1, 1'b0, b);
    check("R2 five ones pins functional", {pin_oe, pin_out}, {pin_func_oe, pin_func_out});
    step(1'b0, 1'b0, b);
    shift_dr(64'h0, 32, -1, r);
    check("R2 five ones idcode", r[31:0], IDC);

    // R2 async trst
    shift_ir(4'h0, c);
    shift_dr(64'(p), BSR_W, -1, r);
    #2 trst = 1'b1; #1;
    check("R2 trst pins functional", {pin_oe, pin_out}, {pin_func_oe, pin_func_out});
    @(negedge tck); #1; trst = 1'b0;
    step(1'b0, 1'b0, b);
    shift_dr(64'h0, 32, -1, r);
    check("R2 trst idcode", r[31:0], IDC);

    // R12 disable bit
    shift_ir(4'h0, c);
    shift_dr(64'(p), BSR_W, -1, r);
    #2 tap_disable = 1'b1; #1;
    check("R12 disable pins functional", {pin_oe, pin_out}, {pin_func_oe, pin_func_out});
    saw_oe = 1'b0;
    shift_dr(64'h0, 32, -1, r);
    check("R12 disable tdo muted", saw_oe, 0);
    tap_disable = 1'b0;
    step(1'b0, 1'b0, b);
    shift_dr(64'h0, 32, -1, r);
    check("R12 re-enable idcode", r[31:0], IDC);

    // R12 fuse
    shift_ir(4'h0, c);
    shift_dr(64'(p), BSR_W, -1, r);
    #2 fuse_prog = 1'b0; #1;
    check("R12 fuse pins functional", {pin_oe, pin_out}, {pin_func_oe, pin_func_out});
    saw_oe = 1'b0;
    shift_dr(64'h0, 32, -1, r);
    check("R12 fuse tdo muted", saw_oe, 0);
    fuse_prog = 1'b1;
    step(1'b0, 1'b0, b);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule